// File: doc/BRIEF.md
# SIMD Media Instruction Fault Checker

This block decides whether a 128-bit packed media instruction may go ahead. The decode and address stages give it a request strobe and a set of qualifying inputs. These are the extension-present bit, three control bits (emulation, task switched, OS save/restore support), the processor mode, a memory-operand flag, the low address bits, and segment status flags. From these the block works out the single exception the instruction must raise, or clears the fault when none applies.

The verdict is captured on the request strobe. It holds on the outputs until the next strobe, so a trap-delivery stage can sample it whenever it is ready. The block only applies the fault rules. Page walks, limit arithmetic and the trap itself are done elsewhere. The alignment rule has two forms. A cleared misalignment-mask bit makes any misaligned 16-byte operand a protection fault. A set mask bit makes misalignment an alignment-check fault, and only when alignment checking is enabled.

Top module: `simd_fault_check`

## Requirements
- R1: After reset, and before the first request, `fault_valid` is 0 and `fault_code` is 0 (no fault).
- R2: A request with `ext_present` = 0 yields invalid opcode, code 1.
- R3: A request with `cr_emulate` = 1 yields code 1.
- R4: A request with `os_fxsave_on` = 0 yields code 1.
- R5: A request with `cr_task_sw` = 1, when no code-1 cause holds, yields device-not-available, code 2.
- R6: With a memory operand whose low address bits are not all zero and `misalign_mask` = 0, the result is general protection, code 3.
- R7: With a misaligned memory operand and `misalign_mask` = 1, the result is alignment check, code 5, only when `align_chk_on` = 1 and the mode is not real (mode 0). Otherwise the misalignment has no effect.
- R8: `seg_null` = 1 with a memory operand yields code 3 in protected modes (mode 2 or 3). In real (0) and virtual-8086 (1) modes it has no effect.
- R9: `limit_fault` = 1 with a memory operand yields stack fault, code 4, when `stack_ref` = 1, and code 3 otherwise.
- R10: When several causes hold, the order is code 1, then code 2, then the segment/alignment group, then code 5. Within the group the order is null segment, then limit, then misalignment.
- R11: With `mem_op` = 0, the segment, limit, alignment and alignment-check inputs have no effect.
- R12: The outputs change only on the clock edge after a cycle with `req_valid` = 1. Otherwise they hold.
- R13: `fault_valid` is 1 exactly when `fault_code` is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe: capture a verdict this cycle |
| ext_present | input | 1 | Media extension reported present |
| cr_emulate | input | 1 | Emulation control bit |
| cr_task_sw | input | 1 | Task-switched control bit |
| os_fxsave_on | input | 1 | OS supports extended state save/restore |
| misalign_mask | input | 1 | 1 = misalignment is checked by alignment check, not protection |
| align_chk_on | input | 1 | Alignment checking enabled |
| cpu_mode | input | 2 | 0 real, 1 virtual-8086, 2 protected, 3 long |
| mem_op | input | 1 | Instruction has a memory operand |
| addr_lo | input | ALIGN_LSB (4) | Low address bits of the operand |
| seg_null | input | 1 | Null data segment used for the reference |
| limit_fault | input | 1 | Limit exceeded or address non-canonical |
| stack_ref | input | 1 | Reference goes through the stack segment |
| fault_valid | output | 1 | An exception must be raised |
| fault_code | output | 3 | 0 none, 1 invalid opcode, 2 device not available, 3 general protection, 4 stack, 5 alignment check |

## Verification
The hardest cases to reach are the ones where several causes hold at once and only the priority order picks the winner. Examples are a null segment together with a stack limit fault, or misalignment with the mask set in real mode. Uniformly random control bits nearly always end in invalid opcode, so these cases rarely come up by chance. The stimulus therefore biases the enable bits toward their legal values, so that the memory rules are reached on most requests. It also adds directed requests that stack two or three memory causes in each mode, plus idle cycles that test holding between strobes.

// File: rtl/simd_fault_pkg.sv
package simd_fault_pkg;

  typedef enum logic [2:0] {
    FC_NONE = 3'd0,
    FC_UD   = 3'd1,
    FC_NM   = 3'd2,
    FC_GP   = 3'd3,
    FC_SS   = 3'd4,
    FC_AC   = 3'd5
  } fault_code_e;

  typedef enum logic [1:0] {
    MD_REAL = 2'd0,
    MD_V86  = 2'd1,
    MD_PROT = 2'd2,
    MD_LONG = 2'd3
  } cpu_mode_e;

  typedef struct packed {
    logic ud;
    logic nm;
    logic null_gp;
    logic lim_ss;
    logic lim_gp;
    logic align_gp;
    logic align_ac;
  } fault_flags_t;

endpackage

// File: rtl/sfc_rst_sync.sv
module sfc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/sfc_enable_gate.sv
module sfc_enable_gate (
  input  logic ext_present,
  input  logic cr_emulate,
  input  logic cr_task_sw,
  input  logic os_fxsave_on,
  output logic ud,
  output logic nm
);
  always_comb begin
    ud = !ext_present || cr_emulate || !os_fxsave_on;
    nm = cr_task_sw;
  end
endmodule

// File: rtl/sfc_mem_rules.sv
module sfc_mem_rules
  import simd_fault_pkg::*;
#(
  parameter int ALIGN_LSB = 4
) (
  input  logic                 mem_op,
  input  logic [1:0]           cpu_mode,
  input  logic [ALIGN_LSB-1:0] addr_lo,
  input  logic                 misalign_mask,
  input  logic                 align_chk_on,
  input  logic                 seg_null,
  input  logic                 limit_fault,
  input  logic                 stack_ref,
  output logic                 null_gp,
  output logic                 lim_ss,
  output logic                 lim_gp,
  output logic                 align_gp,
  output logic                 align_ac
);
  logic [ALIGN_LSB:0] or_chain;
  logic               misaligned;
  logic               prot_mode;
  logic               not_real;

  assign or_chain[0] = 1'b0;
  for (genvar b = 0; b < ALIGN_LSB; b++) begin : g_mis
    assign or_chain[b+1] = or_chain[b] | addr_lo[b];
  end

  always_comb begin
    misaligned = or_chain[ALIGN_LSB];
    prot_mode  = cpu_mode[1];
    not_real   = (cpu_mode != MD_REAL);
    null_gp    = mem_op && seg_null && prot_mode;
    lim_ss     = mem_op && limit_fault && stack_ref;
    lim_gp     = mem_op && limit_fault && !stack_ref;
    align_gp   = mem_op && misaligned && !misalign_mask;
    align_ac   = mem_op && misaligned && misalign_mask && align_chk_on && not_real;
  end
endmodule

// File: rtl/sfc_prio_encode.sv
module sfc_prio_encode
  import simd_fault_pkg::*;
(
  input  fault_flags_t flags,
  output fault_code_e  code
);
  always_comb begin
    if (flags.ud)            code = FC_UD;
    else if (flags.nm)       code = FC_NM;
    else if (flags.null_gp)  code = FC_GP;
    else if (flags.lim_ss)   code = FC_SS;
    else if (flags.lim_gp)   code = FC_GP;
    else if (flags.align_gp) code = FC_GP;
    else if (flags.align_ac) code = FC_AC;
    else                     code = FC_NONE;
  end
endmodule

// File: rtl/simd_fault_check.sv
module simd_fault_check
  import simd_fault_pkg::*;
#(
  parameter  int ALIGN_BYTES = 16,
  parameter  int SYNC_STAGES = 2,
  localparam int ALIGN_LSB   = $clog2(ALIGN_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 ext_present,
  input  logic                 cr_emulate,
  input  logic                 cr_task_sw,
  input  logic                 os_fxsave_on,
  input  logic                 misalign_mask,
  input  logic                 align_chk_on,
  input  logic [1:0]           cpu_mode,
  input  logic                 mem_op,
  input  logic [ALIGN_LSB-1:0] addr_lo,
  input  logic                 seg_null,
  input  logic                 limit_fault,
  input  logic                 stack_ref,
  output logic                 fault_valid,
  output logic [2:0]           fault_code
);
  logic         rst_n_int;
  fault_flags_t flags;
  fault_code_e  code_nxt_raw;
  logic         valid_d, valid_q;
  logic [2:0]   code_d, code_q;

  sfc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  sfc_enable_gate u_gate (
    .ext_present  (ext_present),
    .cr_emulate   (cr_emulate),
    .cr_task_sw   (cr_task_sw),
    .os_fxsave_on (os_fxsave_on),
    .ud           (flags.ud),
    .nm           (flags.nm)
  );

  sfc_mem_rules #(.ALIGN_LSB(ALIGN_LSB)) u_mem (
    .mem_op        (mem_op),
    .cpu_mode      (cpu_mode),
    .addr_lo       (addr_lo),
    .misalign_mask (misalign_mask),
    .align_chk_on  (align_chk_on),
    .seg_null      (seg_null),
    .limit_fault   (limit_fault),
    .stack_ref     (stack_ref),
    .null_gp       (flags.null_gp),
    .lim_ss        (flags.lim_ss),
    .lim_gp        (flags.lim_gp),
    .align_gp      (flags.align_gp),
    .align_ac      (flags.align_ac)
  );

  sfc_prio_encode u_prio (
    .flags (flags),
    .code  (code_nxt_raw)
  );

  // next state: capture only on the request strobe
  always_comb begin
    valid_d = valid_q;
    code_d  = code_q;
    if (req_valid) begin
      code_d  = code_nxt_raw;
      valid_d = (code_nxt_raw != FC_NONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      valid_q <= 1'b0;
      code_q  <= 3'd0;
    end else begin
      valid_q <= valid_d;
      code_q  <= code_d;
    end
  end

  assign fault_valid = valid_q;
  assign fault_code  = code_q;
endmodule

// File: rtl/simd_fault_check_sva.sv
module simd_fault_check_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       ext_present,
  input logic       cr_emulate,
  input logic       cr_task_sw,
  input logic       os_fxsave_on,
  input logic [1:0] cpu_mode,
  input logic       mem_op,
  input logic       seg_null,
  input logic       fault_valid,
  input logic [2:0] fault_code
);
  logic en_ok;
  assign en_ok = ext_present && !cr_emulate && os_fxsave_on;

  // R2
  ud_no_feature_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !ext_present |=> fault_valid && fault_code == 3'd1);

  // R3
  ud_emulate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && cr_emulate |=> fault_code == 3'd1);

  // R5
  nm_task_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && en_ok && cr_task_sw |=> fault_code == 3'd2);

  // R11
  no_mem_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && en_ok && !cr_task_sw && !mem_op |=> !fault_valid);

  // R8
  null_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && en_ok && !cr_task_sw && mem_op && seg_null && cpu_mode[1]
    |=> fault_code == 3'd3);

  // R12
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(fault_valid) && $stable(fault_code));

  // R13
  valid_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid == (fault_code != 3'd0));
endmodule

bind simd_fault_check simd_fault_check_sva u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .ext_present  (ext_present),
  .cr_emulate   (cr_emulate),
  .cr_task_sw   (cr_task_sw),
  .os_fxsave_on (os_fxsave_on),
  .cpu_mode     (cpu_mode),
  .mem_op       (mem_op),
  .seg_null     (seg_null),
  .fault_valid  (fault_valid),
  .fault_code   (fault_code)
);

// File: tb/test_simd_fault_check.sv
module test_simd_fault_check;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, ext_present, cr_emulate, cr_task_sw, os_fxsave_on;
  logic       misalign_mask, align_chk_on, mem_op, seg_null, limit_fault, stack_ref;
  logic [1:0] cpu_mode;
  logic [3:0] addr_lo;
  logic       fault_valid;
  logic [2:0] fault_code;

  int checks = 0;
  int failures = 0;
  int exp_code = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  simd_fault_check i_simd_fault_check (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ext_present(ext_present),
    .cr_emulate(cr_emulate), .cr_task_sw(cr_task_sw), .os_fxsave_on(os_fxsave_on),
    .misalign_mask(misalign_mask), .align_chk_on(align_chk_on), .cpu_mode(cpu_mode),
    .mem_op(mem_op), .addr_lo(addr_lo), .seg_null(seg_null), .limit_fault(limit_fault),
    .stack_ref(stack_ref), .fault_valid(fault_valid), .fault_code(fault_code)
  );

  // behavioural reference: codes 0 none,1 UD,2 NM,3 GP,4 SS,5 AC
  function automatic int ref_code();
    if (!ext_present || cr_emulate || !os_fxsave_on) return 1;
    if (cr_task_sw) return 2;
    if (mem_op) begin
      if (seg_null && cpu_mode >= 2) return 3;
      if (limit_fault) return stack_ref ? 4 : 3;
      if (addr_lo != 0 && !misalign_mask) return 3;
      if (addr_lo != 0 && align_chk_on && cpu_mode != 0) return 5;
    end
    return 0;
  endfunction

  task automatic compare(string tag);
    checks++;
    if (fault_code !== 3'(exp_code) || fault_valid !== (exp_code != 0)) begin
      failures++;
      $display("FAIL %s: got valid=%0b code=%0d expected valid=%0b code=%0d",
               tag, fault_valid, fault_code, exp_code != 0, exp_code);
    end
  endtask

  // drive at negedge, DUT captures at posedge, compare at next negedge
  task automatic step(string tag, bit req, bit feat, bit em, bit ts, bit osfx,
                      bit mask, bit ac, int mode, bit mem, int addr,
                      bit nul, bit lim, bit stk);
    req_valid = req; ext_present = feat; cr_emulate = em; cr_task_sw = ts;
    os_fxsave_on = osfx; misalign_mask = mask; align_chk_on = ac;
    cpu_mode = 2'(mode); mem_op = mem; addr_lo = 4'(addr);
    seg_null = nul; limit_fault = lim; stack_ref = stk;
    if (req) exp_code = ref_code();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got no finish expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; ext_present = 1; cr_emulate = 0; cr_task_sw = 0; os_fxsave_on = 1;
    misalign_mask = 0; align_chk_on = 0; cpu_mode = 2; mem_op = 0; addr_lo = 0;
    seg_null = 0; limit_fault = 0; stack_ref = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare("R1");

    //            tag   req f em ts os mk ac md mem addr nul lim stk
    step("R2",  1, 0, 0, 0, 1, 0, 0, 2, 0, 0, 0, 0, 0);
    step("R11", 1, 1, 0, 0, 1, 0, 0, 2, 0, 5, 1, 1, 1);
    step("R3",  1, 1, 1, 0, 1, 0, 0, 2, 1, 0, 0, 0, 0);
    step("R4",  1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R5",  1, 1, 0, 1, 1, 0, 0, 2, 1, 3, 1, 1, 1);
    step("R10", 1, 0, 0, 1, 1, 0, 0, 2, 0, 0, 0, 0, 0);
    step("R6",  1, 1, 0, 0, 1, 0, 0, 0, 1, 8, 0, 0, 0);
    step("R6",  1, 1, 0, 0, 1, 0, 0, 2, 1, 1, 0, 0, 0);
    step("R7",  1, 1, 0, 0, 1, 1, 1, 2, 1, 4, 0, 0, 0);
    step("R7",  1, 1, 0, 0, 1, 1, 1, 1, 1, 2, 0, 0, 0);
    step("R7",  1, 1, 0, 0, 1, 1, 1, 0, 1, 4, 0, 0, 0);
    step("R7",  1, 1, 0, 0, 1, 1, 0, 3, 1, 4, 0, 0, 0);
    step("R8",  1, 1, 0, 0, 1, 0, 0, 2, 1, 0, 1, 0, 0);
    step("R8",  1, 1, 0, 0, 1, 0, 0, 3, 1, 0, 1, 0, 0);
    step("R8",  1, 1, 0, 0, 1, 0, 0, 1, 1, 0, 1, 0, 0);
    step("R8",  1, 1, 0, 0, 1, 0, 0, 0, 1, 0, 1, 0, 0);
    step("R9",  1, 1, 0, 0, 1, 0, 0, 2, 1, 0, 0, 1, 1);
    step("R9",  1, 1, 0, 0, 1, 0, 0, 0, 1, 0, 0, 1, 0);
    step("R10", 1, 1, 0, 0, 1, 0, 0, 2, 1, 4, 1, 1, 1);
    step("R10", 1, 1, 0, 0, 1, 1, 1, 1, 1, 4, 1, 1, 1);
    step("R10", 1, 1, 0, 0, 1, 0, 1, 2, 1, 4, 0, 1, 0);
    step("R10", 1, 1, 0, 0, 1, 1, 1, 2, 1, 4, 0, 1, 1);
    // R12: hold with idle cycles while inputs would give other codes
    step("R12", 1, 1, 0, 0, 1, 0, 0, 2, 1, 0, 0, 1, 1);
    step("R12", 0, 0, 1, 1, 0, 0, 0, 2, 0, 0, 0, 0, 0);
    step("R12", 0, 1, 0, 0, 1, 0, 0, 2, 0, 0, 0, 0, 0);
    step("R13", 1, 1, 0, 0, 1, 0, 0, 2, 0, 0, 0, 0, 0);
    step("R12", 0, 0, 0, 0, 1, 0, 0, 2, 0, 0, 0, 0, 0);

    // biased random mix, R10 covers the ordering of all rules
    for (int i = 0; i < 4000; i++) begin
      step("R10", ($urandom % 4) != 0, ($urandom % 16) != 0, ($urandom % 16) == 0,
           ($urandom % 10) == 0, ($urandom % 16) != 0, $urandom % 2, $urandom % 2,
           $urandom % 4, ($urandom % 5) != 0,
           (($urandom % 2) != 0) ? 0 : ($urandom % 16),
           ($urandom % 5) == 0, ($urandom % 5) == 0, $urandom % 2);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule